// File: doc/BRIEF.md
# Floating-Point Result Rounding Unit

This block takes the unrounded result of a floating-point operation, held as a sign, a signed exponent and a 67-bit intermediate mantissa, and rounds it to single, double or extended precision. The mantissa carries the integer bit in bit 66. The bits below the target significand supply the guard, round and sticky information. Where those bits sit depends on the precision chosen, and one of four IEEE 754 rounding directions sets whether the kept significand is incremented.

The result is a 64-bit left-aligned significand with every bit below the target precision cleared, an exponent corrected for a carry out of the significand, an inexact flag and an overflow flag. The unit is a two-stage pipeline with no stall. A request presented with `in_valid` comes out two clock cycles later with `out_valid`, so a new request can be accepted on every cycle.

Top module: `fp_round_unit`

## Requirements
- R1: `out_valid` rises exactly two rising clock edges after a request is presented with `in_valid` high. While `rst` is high and after it is released, with no request in flight, `out_valid`, `out_mant`, `out_exp`, `out_inexact` and `out_overflow` are all 0.
- R2: `in_prec` selects the significand width. 00 selects 24 bits, kept from `in_mant[66:43]`. 01 selects 53 bits, kept from `in_mant[66:14]`. 10 and 11 both select 64 bits, kept from `in_mant[66:3]`. `out_mant` holds the rounded significand left-aligned from bit 63, and all lower bits are 0.
- R3: With `in_mode` 00 (nearest), the significand is incremented by one unit in its last place when the first discarded (guard) bit is 1 and any lower discarded bit is 1.
- R4: With `in_mode` 00, an exact halfway case (guard 1, all lower discarded bits 0) increments only when the kept LSB is 1, so the result always ends in an even LSB.
- R5: With `in_mode` 01 (toward zero), the significand is never incremented and the exponent is passed through unchanged.
- R6: With `in_mode` 11 (toward plus infinity), a positive value (`in_sign` 0) with any nonzero discarded bit is incremented. With `in_mode` 10 (toward minus infinity), a negative value with any nonzero discarded bit is incremented. In every other case under these two modes, nothing is incremented.
- R7: When the increment carries out of the top of the significand, `out_mant` becomes 1 followed by zeros and `out_exp` is `in_exp` plus 1. Otherwise `out_exp` equals `in_exp`.
- R8: `out_inexact` is 1 exactly when any discarded bit of the intermediate mantissa is nonzero.
- R9: `out_overflow` is 1 exactly when the adjusted exponent, read as an 18-bit two's-complement unbiased value, exceeds 127 (single), 1023 (double) or 16383 (extended).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_exp | input | 18 | Unbiased exponent, two's complement |
| in_mant | input | 67 | Intermediate mantissa, integer bit at 66 |
| in_prec | input | 2 | Target precision select |
| in_mode | input | 2 | Rounding direction |
| out_valid | output | 1 | Result present this cycle |
| out_mant | output | 64 | Rounded significand, left-aligned |
| out_exp | output | 18 | Adjusted exponent |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_overflow | output | 1 | Exponent beyond the precision's range |

## Verification
The bench targets exact halfway cases with both LSB values. A design that rounds halves upward would come out odd where an even result is required, and one that ignores the LSB would never break a tie upward. It also probes each directed mode with both signs: swapping the minus- and plus-infinity encodings or ignoring the sign increments the wrong magnitude. All-ones significands are rounded upward at the exponent limit of each precision. A missing renormalization shows up as a zero significand with an unchanged exponent, and a range check tied to the wrong precision misses or invents overflow. Each precision is exercised with discarded bits that straddle the neighbouring precision's boundary, which exposes a misplaced guard or sticky position.

// File: rtl/fprnd_pkg.sv
package fprnd_pkg;

    localparam int MANT_W   = 67;
    localparam int SIG_W    = 64;
    localparam int EXP_W    = 18;
    localparam int NUM_PREC = 3;
    localparam int PIDX_W   = $clog2(NUM_PREC);

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_ZERO = 2'b01,
        RND_DOWN = 2'b10,
        RND_UP   = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        PR_SGL     = 2'b00,
        PR_DBL     = 2'b01,
        PR_EXT     = 2'b10,
        PR_EXT_ALT = 2'b11
    } prec_e;

    // significand width for each precision index
    function automatic int sig_bits(int idx);
        case (idx)
            0:       return 24;
            1:       return 53;
            default: return 64;
        endcase
    endfunction

    // exponent field width for each precision index
    function automatic int exp_bits(int idx);
        case (idx)
            0:       return 8;
            1:       return 11;
            default: return 15;
        endcase
    endfunction

    function automatic logic [PIDX_W-1:0] prec_index(prec_e p);
        case (p)
            PR_SGL:  return PIDX_W'(0);
            PR_DBL:  return PIDX_W'(1);
            default: return PIDX_W'(2);
        endcase
    endfunction

    function automatic logic signed [EXP_W-1:0] exp_limit(int idx);
        return EXP_W'((1 << (exp_bits(idx) - 1)) - 1);
    endfunction

    function automatic logic [SIG_W-1:0] ulp_vec(int idx);
        logic [SIG_W-1:0] v;
        v = '0;
        v[SIG_W - sig_bits(idx)] = 1'b1;
        return v;
    endfunction

    typedef struct packed {
        logic                     sign;
        logic signed [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]         sig;
        logic                     guard;
        logic                     rnd;
        logic                     sticky;
        logic                     inc;
        logic [PIDX_W-1:0]        pidx;
        rnd_mode_e                mode;
    } split_t;

    typedef struct packed {
        logic [SIG_W-1:0]         mant;
        logic signed [EXP_W-1:0]  exp;
        logic                     inexact;
        logic                     ovf;
    } result_t;

endpackage

// File: rtl/fprnd_split.sv
module fprnd_split
    import fprnd_pkg::*;
(
    input  logic [MANT_W-1:0] mant,
    input  prec_e             prec,
    output logic [SIG_W-1:0]  sig,
    output logic              lsb,
    output logic              guard,
    output logic              rnd,
    output logic              sticky,
    output logic [PIDX_W-1:0] pidx
);
    logic [SIG_W-1:0] c_sig    [NUM_PREC];
    logic             c_lsb    [NUM_PREC];
    logic             c_guard  [NUM_PREC];
    logic             c_rnd    [NUM_PREC];
    logic             c_sticky [NUM_PREC];

    logic [SIG_W-1:0] top_bits;
    assign top_bits = mant[MANT_W-1 -: SIG_W];

    for (genvar p = 0; p < NUM_PREC; p++) begin : g_prec
        localparam int W     = sig_bits(p);
        localparam int G_POS = MANT_W - 1 - W;
        assign c_sig[p]    = top_bits & ~({SIG_W{1'b1}} >> W);
        assign c_lsb[p]    = mant[MANT_W - W];
        assign c_guard[p]  = mant[G_POS];
        assign c_rnd[p]    = mant[G_POS - 1];
        assign c_sticky[p] = |(mant & ({MANT_W{1'b1}} >> (W + 2)));
    end

    always_comb begin
        pidx   = prec_index(prec);
        sig    = c_sig[0];
        lsb    = c_lsb[0];
        guard  = c_guard[0];
        rnd    = c_rnd[0];
        sticky = c_sticky[0];
        for (int i = 1; i < NUM_PREC; i++) begin
            if (pidx == PIDX_W'(i)) begin
                sig    = c_sig[i];
                lsb    = c_lsb[i];
                guard  = c_guard[i];
                rnd    = c_rnd[i];
                sticky = c_sticky[i];
            end
        end
    end
endmodule

// File: rtl/fprnd_decide.sv
module fprnd_decide
    import fprnd_pkg::*;
(
    input  rnd_mode_e mode,
    input  logic      sign,
    input  logic      lsb,
    input  logic      guard,
    input  logic      rnd,
    input  logic      sticky,
    output logic      inc
);
    logic lost;
    assign lost = guard | rnd | sticky;

    always_comb begin
        unique case (mode)
            RND_NEAR: inc = guard & (lsb | rnd | sticky);
            RND_ZERO: inc = 1'b0;
            RND_DOWN: inc = sign & lost;
            RND_UP:   inc = ~sign & lost;
            default:  inc = 1'b0;
        endcase
    end

    // R4: an exact half with an even LSB stays put
    always_comb begin
        a_r4_tie_even: assert (!(mode == RND_NEAR && guard && !rnd && !sticky && !lsb && inc));
        // R6: directed modes never move a value away from their own direction
        a_r6_direction: assert (!(((mode == RND_DOWN && !sign) || (mode == RND_UP && sign)) && inc));
        // R5: toward zero never increments
        a_r5_zero_no_inc: assert (!(mode == RND_ZERO && inc));
    end
endmodule

// File: rtl/fprnd_adjust.sv
module fprnd_adjust
    import fprnd_pkg::*;
(
    input  logic [SIG_W-1:0]        sig,
    input  logic                    inc,
    input  logic [PIDX_W-1:0]       pidx,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [SIG_W-1:0]        mant_out,
    output logic signed [EXP_W-1:0] exp_out,
    output logic                    ovf
);
    logic [SIG_W-1:0]        ulp;
    logic signed [EXP_W-1:0] lim;
    logic [SIG_W:0]          sum;
    logic                    carry;

    always_comb begin
        ulp = ulp_vec(NUM_PREC - 1);
        lim = exp_limit(NUM_PREC - 1);
        for (int i = 0; i < NUM_PREC - 1; i++) begin
            if (pidx == PIDX_W'(i)) begin
                ulp = ulp_vec(i);
                lim = exp_limit(i);
            end
        end
    end

    assign sum      = {1'b0, sig} + (inc ? {1'b0, ulp} : '0);
    assign carry    = sum[SIG_W];
    assign mant_out = carry ? {1'b1, sum[SIG_W-1:1]} : sum[SIG_W-1:0];
    assign exp_out  = exp_in + EXP_W'(carry);
    assign ovf      = exp_out > lim;

    // R7: a carry out leaves exactly the integer bit set
    always_comb begin
        a_r7_carry_shape: assert (!carry || mant_out == {1'b1, {(SIG_W-1){1'b0}}});
    end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
    import fprnd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic [1:0]        in_prec,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [SIG_W-1:0]  out_mant,
    output logic [EXP_W-1:0]  out_exp,
    output logic              out_inexact,
    output logic              out_overflow
);
    // stage 1: field split and increment decision
    split_t            s1_d, s1_q;
    logic              s1_valid;
    logic              lsb_w;
    logic [SIG_W-1:0]  sig_w;
    logic              g_w, r_w, s_w, inc_w;
    logic [PIDX_W-1:0] pidx_w;

    fprnd_split u_split (
        .mant   (in_mant),
        .prec   (prec_e'(in_prec)),
        .sig    (sig_w),
        .lsb    (lsb_w),
        .guard  (g_w),
        .rnd    (r_w),
        .sticky (s_w),
        .pidx   (pidx_w)
    );

    fprnd_decide u_decide (
        .mode   (rnd_mode_e'(in_mode)),
        .sign   (in_sign),
        .lsb    (lsb_w),
        .guard  (g_w),
        .rnd    (r_w),
        .sticky (s_w),
        .inc    (inc_w)
    );

    always_comb begin
        s1_d.sign   = in_sign;
        s1_d.exp    = in_exp;
        s1_d.sig    = sig_w;
        s1_d.guard  = g_w;
        s1_d.rnd    = r_w;
        s1_d.sticky = s_w;
        s1_d.inc    = inc_w;
        s1_d.pidx   = pidx_w;
        s1_d.mode   = rnd_mode_e'(in_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_q     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_q <= s1_d;
        end
    end

    // stage 2: increment, renormalize, range check
    result_t r_d, r_q;
    logic    r_valid;

    fprnd_adjust u_adjust (
        .sig      (s1_q.sig),
        .inc      (s1_q.inc),
        .pidx     (s1_q.pidx),
        .exp_in   (s1_q.exp),
        .mant_out (r_d.mant),
        .exp_out  (r_d.exp),
        .ovf      (r_d.ovf)
    );
    assign r_d.inexact = s1_q.guard | s1_q.rnd | s1_q.sticky;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid <= 1'b0;
            r_q     <= '0;
        end else begin
            r_valid <= s1_valid;
            if (s1_valid) r_q <= r_d;
        end
    end

    assign out_valid    = r_valid;
    assign out_mant     = r_q.mant;
    assign out_exp      = r_q.exp;
    assign out_inexact  = r_q.inexact;
    assign out_overflow = r_q.ovf;

    // R1: the second stage follows the first by one cycle
    a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
    a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);
    // R5: toward zero passes significand and exponent through
    a_r5_zero_pass: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_q.mode == RND_ZERO) |=>
            (out_mant == $past(s1_q.sig) && out_exp == $past(s1_q.exp)));
    // R8: inexact reflects the discarded bits held in stage 1
    a_r8_inexact: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_inexact == $past(s1_q.guard | s1_q.rnd | s1_q.sticky));
    // R9: overflow only above the smallest precision's limit
    a_r9_ovf_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_overflow) |-> ($signed(out_exp) > 18'sd127));
endmodule

// File: tb/test_fp_round_unit.sv
module test_fp_round_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_sign;
    logic [17:0]  in_exp;
    logic [66:0]  in_mant;
    logic [1:0]   in_prec;
    logic [1:0]   in_mode;
    logic         out_valid;
    logic [63:0]  out_mant;
    logic [17:0]  out_exp;
    logic         out_inexact;
    logic         out_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    fp_round_unit i_fp_round_unit (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sign      (in_sign),
        .in_exp       (in_exp),
        .in_mant      (in_mant),
        .in_prec      (in_prec),
        .in_mode      (in_mode),
        .out_valid    (out_valid),
        .out_mant     (out_mant),
        .out_exp      (out_exp),
        .out_inexact  (out_inexact),
        .out_overflow (out_overflow)
    );

    typedef struct {
        bit          valid;
        logic [63:0] mant;
        logic [17:0] exp;
        bit          inexact;
        bit          ovf;
        string       tag;
    } exp_t;

    exp_t p1, p2;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // reference: round by comparing the discarded remainder with one half ulp
    function automatic exp_t model(bit sign, logic [17:0] e, logic [66:0] m,
                                   logic [1:0] prec, logic [1:0] mode, string tag);
        exp_t r;
        int w, drop, lim, ev;
        logic [67:0] full, ulp, floorv, rem, half, res;
        bit up, any;
        w    = (prec == 2'b00) ? 24 : (prec == 2'b01) ? 53 : 64;
        lim  = (prec == 2'b00) ? 127 : (prec == 2'b01) ? 1023 : 16383;
        drop = 67 - w;
        full = {1'b0, m};
        ulp  = 68'(1) << drop;
        rem  = full & (ulp - 68'(1));
        floorv = full - rem;
        half = ulp >> 1;
        any  = (rem != 0);
        case (mode)
            2'b00:   up = (rem > half) || (rem == half && floorv[drop]);
            2'b01:   up = 0;
            2'b10:   up = sign && any;
            default: up = !sign && any;
        endcase
        res = floorv + (up ? ulp : 68'(0));
        ev  = $signed(e);
        if (res[67]) begin
            r.mant = res[67:4];
            ev = ev + 1;
        end else begin
            r.mant = res[66:3];
        end
        r.exp     = 18'(ev);
        r.inexact = any;
        r.ovf     = (ev > lim);
        r.valid   = 1;
        r.tag     = tag;
        return r;
    endfunction

    task automatic compare();
        check(out_valid == p2.valid, "R1", "out_valid", 64'(out_valid), 64'(p2.valid));
        if (p2.valid) begin
            check(out_mant == p2.mant, p2.tag, "out_mant", out_mant, p2.mant);
            check(out_exp == p2.exp, "R7", "out_exp", 64'(out_exp), 64'(p2.exp));
            check(out_inexact == p2.inexact, "R8", "out_inexact", 64'(out_inexact), 64'(p2.inexact));
            check(out_overflow == p2.ovf, "R9", "out_overflow", 64'(out_overflow), 64'(p2.ovf));
        end
    endtask

    task automatic step(bit v, bit sign, logic [17:0] e, logic [66:0] m,
                        logic [1:0] prec, logic [1:0] mode, string tag);
        @(negedge clk);
        compare();
        p2 = p1;
        if (v) p1 = model(sign, e, m, prec, mode, tag);
        else   p1.valid = 0;
        in_valid = v;
        in_sign  = sign;
        in_exp   = e;
        in_mant  = m;
        in_prec  = prec;
        in_mode  = mode;
    endtask

    task automatic idle();
        step(0, 0, '0, '0, 2'b00, 2'b00, "R1");
    endtask

    localparam logic [66:0] ONE = 67'(1);
    localparam logic [66:0] TOP = ONE << 66;

    initial begin
        repeat (25000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        p1.valid = 0;
        p2.valid = 0;
        rst = 1;
        in_valid = 0; in_sign = 0; in_exp = '0; in_mant = '0; in_prec = '0; in_mode = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 0 && out_mant == 0 && out_exp == 0 && !out_inexact && !out_overflow,
              "R1", "reset outputs", {out_mant[62:0], out_valid}, 64'(0));
        rst = 0;
        idle();
        idle();

        // R4 ties in single: lsb bit 43, guard 42
        step(1, 0, 18'd5, TOP | (ONE << 42), 2'b00, 2'b00, "R4");
        step(1, 0, 18'd5, TOP | (ONE << 43) | (ONE << 42), 2'b00, 2'b00, "R4");
        // R3 above half, below half
        step(1, 0, 18'd5, TOP | (ONE << 42) | ONE, 2'b00, 2'b00, "R3");
        step(1, 0, 18'd5, TOP | (ONE << 41) | (ONE << 43), 2'b00, 2'b00, "R3");
        // R4 tie in double (lsb 14, guard 13) and extended (lsb 3, guard 2)
        step(1, 1, 18'd9, TOP | (ONE << 13), 2'b01, 2'b00, "R4");
        step(1, 1, 18'd9, TOP | (ONE << 14) | (ONE << 13), 2'b01, 2'b00, "R4");
        step(1, 0, 18'd9, TOP | (ONE << 2), 2'b10, 2'b00, "R4");
        step(1, 0, 18'd9, TOP | (ONE << 3) | (ONE << 2), 2'b11, 2'b00, "R4");
        // R5 toward zero
        step(1, 0, 18'd1, TOP | (ONE << 42) | (ONE << 41), 2'b00, 2'b01, "R5");
        step(1, 1, 18'd1, {67{1'b1}}, 2'b10, 2'b01, "R5");
        // R6 directed modes with both signs, only sticky set
        step(1, 0, 18'd2, TOP | ONE, 2'b00, 2'b11, "R6");
        step(1, 1, 18'd2, TOP | ONE, 2'b00, 2'b11, "R6");
        step(1, 1, 18'd2, TOP | ONE, 2'b01, 2'b10, "R6");
        step(1, 0, 18'd2, TOP | ONE, 2'b01, 2'b10, "R6");
        // R8 exact values in every mode
        for (int md = 0; md < 4; md++)
            step(1, md[0], 18'd3, TOP | (ONE << 43), 2'b00, 2'(md), "R8");
        // R2 discarded bits that belong to the next precision
        step(1, 0, 18'd4, TOP | (ONE << 20), 2'b00, 2'b11, "R2");
        step(1, 0, 18'd4, TOP | (ONE << 20), 2'b01, 2'b11, "R2");
        step(1, 0, 18'd4, TOP | (ONE << 5), 2'b01, 2'b11, "R2");
        step(1, 0, 18'd4, TOP | (ONE << 5), 2'b10, 2'b11, "R2");
        // R7 and R9 carry out at each precision's limit
        step(1, 0, 18'd127,   {67{1'b1}}, 2'b00, 2'b00, "R7");
        step(1, 0, 18'd126,   {67{1'b1}}, 2'b00, 2'b00, "R7");
        step(1, 0, 18'd1023,  {67{1'b1}}, 2'b01, 2'b00, "R7");
        step(1, 0, 18'd1023,  TOP, 2'b01, 2'b00, "R9");
        step(1, 0, 18'd16383, {67{1'b1}}, 2'b10, 2'b11, "R7");
        step(1, 0, 18'd16383, {67{1'b1}}, 2'b10, 2'b01, "R9");
        step(1, 1, 18'd1024,  TOP, 2'b01, 2'b01, "R9");
        step(1, 1, -18'sd200, {67{1'b1}}, 2'b00, 2'b10, "R7");
        idle();
        idle();

        // random traffic with gaps
        for (int n = 0; n < 1500; n++) begin
            logic [66:0] m;
            logic [17:0] e;
            int k;
            m = {$urandom(), $urandom(), $urandom()};
            m[66] = 1'b1;
            k = $urandom_range(0, 7);
            if (k == 0) m[65:0] = '1;
            if (k == 1) m[41:0] = 42'(1) << 41;
            e = 18'($signed($urandom_range(0, 33000)) - 16500);
            if ($urandom_range(0, 3) == 0) e = 18'($urandom_range(120, 130));
            step($urandom_range(0, 4) != 0, 1'($urandom()), e, m,
                 2'($urandom()), 2'($urandom()), "R3");
        end
        idle();
        idle();
        idle();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule